// File: doc/BRIEF.md
# I2C Byte-Memory Target

This block is an I2C target that gives a bus master read and write access to an internal byte-wide array. It runs on a fast system clock and oversamples the SCL and SDA lines through a short synchronizer. From that sampled view it picks out start, repeated-start and stop conditions and rising and falling SCL edges. Each byte then moves through a small framing engine: the select byte, two address bytes, and a stream of data bytes in either direction.

SDA is never driven high. The block has a single active-high pull-down enable, and the bus line is the wired-AND of the master and this enable. A level input blocks every array update while it is high. Three strap inputs give the low bits of the target's bus address, so that up to eight of these targets can share one bus. The array depth is `2**ADDR_W` bytes. ADDR_W = 14 gives a 16 K x 8 array. The default is a smaller depth. Every address in a transfer uses the low ADDR_W bits of the two address bytes.

The address counter is kept from one transfer to the next. A write followed by a repeated start and a read select gives a random read. A plain read select continues from the location after the last byte that was accessed. A write takes effect with no busy time, so a new select byte is acknowledged straight after the stop.

Top module: `i2c_mem_target`

## Requirements
- R1: The select byte is acknowledged (SDA pulled low during its 9th SCL clock) only when bits 7..4 are 1010 and bits 3..1 equal strap_i[2:0], with bit 3 compared against strap_i[2]. Bit 0 selects the direction: 0 means write, 1 means read.
- R2: After a select byte that does not match, the block leaves SDA released for every later clock, and every later byte is ignored, until the next start.
- R3: In a write, each of the two address bytes (high byte first) is acknowledged. The counter is loaded with the low ADDR_W bits of the 16-bit value, and the upper bits are ignored.
- R4: Each write data byte is acknowledged and stored at the counter's location. The counter then advances by one.
- R5: While wp_i is high, data bytes are still acknowledged and the counter still advances, but no array location changes.
- R6: A read sends bytes MSB first. The block changes SDA only while SCL is low. After a low acknowledge from the master, it sends the next byte from the advancing counter.
- R7: After the master answers a read byte with a high (NACK), the block releases SDA and keeps it released until the next start.
- R8: The counter wraps from 2**ADDR_W-1 to 0, for both writes and reads.
- R9: A repeated start after the address bytes, followed by a read select, reads from the loaded address. A later plain read select continues from the last accessed location plus one.
- R10: After reset and after any stop, SDA is released. The select byte of the next transfer is acknowledged straight after a write's stop.
- R11: A start in the middle of a byte discards the partial byte and restarts select decoding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled serial clock line |
| sda_i | input | 1 | Sampled serial data line |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| wp_i | input | 1 | 1 blocks all array writes |
| strap_i | input | 3 | Pin-strapped low bits of the target's bus address |

## Verification
The hardest state to reach from the ports is the boundary of the address counter: a write or read that crosses the top location into location 0. A second hard case is a plain read select that depends on a counter left behind by an earlier transfer. The stimulus reaches both by loading addresses one or two bytes below the top and by chaining transfers without re-addressing. A behavioural reference model tracks the counter and the memory contents through these chained transfers. A start in the middle of a select byte, and the bytes that follow a mismatched select or a master NACK, are also driven, to check that the block stays silent.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SEL, ST_AHI, ST_ALO, ST_WDAT, ST_RDAT
  } phase_t;
  localparam logic [3:0] TYPE_CODE = 4'b1010;
endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int NLINE = 2;
  logic [NLINE-1:0] raw, lvl, lvl_q;
  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < NLINE; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign lvl[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '1;
    else        lvl_q <= lvl;
  end

  assign scl_lvl   = lvl[1];
  assign sda_lvl   = lvl[0];
  assign scl_rise  = lvl[1] & ~lvl_q[1];
  assign scl_fall  = ~lvl[1] & lvl_q[1];
  assign start_det = lvl[1] & lvl_q[1] & lvl_q[0] & ~lvl[0];
  assign stop_det  = lvl[1] & lvl_q[1] & ~lvl_q[0] & lvl[0];
endmodule

// File: rtl/i2cm_array.sv
module i2cm_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end
  assign rdata = cells[raddr];
endmodule

// File: rtl/i2cm_frame.sv
module i2cm_frame
  import i2cm_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_lvl,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [2:0]        strap,
  input  logic              wp,
  input  logic [7:0]        rd_data,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              sda_oe
);
  localparam logic [3:0] LAST_BIT = 4'd8;

  phase_t            st_q, st_d;
  logic [3:0]        bit_q, bit_d;
  logic              slot_q, slot_d;
  logic              drv_q, drv_d;
  logic              mack_q, mack_d;
  logic [7:0]        shf_q, shf_d;
  logic [7:0]        ahi_q, ahi_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              addr_inc, addr_load;
  logic              sel_match;

  assign sel_match = (shf_q[7:1] == {TYPE_CODE, strap});

  always_comb begin
    st_d = st_q; bit_d = bit_q; slot_d = slot_q; drv_d = drv_q;
    mack_d = mack_q; shf_d = shf_q; ahi_d = ahi_q;
    mem_we = 1'b0; addr_inc = 1'b0; addr_load = 1'b0;
    if (start_det) begin
      st_d = ST_SEL; bit_d = '0; slot_d = 1'b0; drv_d = 1'b0;
    end else if (stop_det) begin
      st_d = ST_IDLE; bit_d = '0; slot_d = 1'b0; drv_d = 1'b0;
    end else if (st_q == ST_RDAT) begin
      if (!slot_q) begin
        if (scl_fall) begin
          if (bit_q == 4'd7) slot_d = 1'b1;
          else begin
            shf_d = {shf_q[6:0], 1'b0};
            bit_d = bit_q + 4'd1;
          end
        end
      end else begin
        if (scl_rise) mack_d = sda_lvl;
        if (scl_fall) begin
          slot_d = 1'b0; bit_d = '0;
          if (!mack_q) begin
            shf_d = rd_data; addr_inc = 1'b1;
          end else st_d = ST_IDLE;
        end
      end
    end else if (st_q != ST_IDLE) begin
      if (!slot_q) begin
        if (scl_rise && bit_q != LAST_BIT) begin
          shf_d = {shf_q[6:0], sda_lvl};
          bit_d = bit_q + 4'd1;
        end
        if (scl_fall && bit_q == LAST_BIT) begin
          slot_d = 1'b1; drv_d = 1'b1;
          case (st_q)
            ST_SEL: if (!sel_match) begin
              st_d = ST_IDLE; slot_d = 1'b0; drv_d = 1'b0;
            end
            ST_AHI:  ahi_d = shf_q;
            ST_ALO:  addr_load = 1'b1;
            ST_WDAT: begin mem_we = !wp; addr_inc = 1'b1; end
            default: ;
          endcase
        end
      end else if (scl_fall) begin
        slot_d = 1'b0; bit_d = '0; drv_d = 1'b0;
        case (st_q)
          ST_SEL: if (shf_q[0]) begin
            st_d = ST_RDAT; shf_d = rd_data; addr_inc = 1'b1;
          end else st_d = ST_AHI;
          ST_AHI:  st_d = ST_ALO;
          ST_ALO:  st_d = ST_WDAT;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    addr_d = addr_q;
    if (addr_load)     addr_d = ADDR_W'({ahi_q, shf_q});
    else if (addr_inc) addr_d = addr_q + ADDR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; bit_q <= '0; slot_q <= 1'b0; drv_q <= 1'b0;
      mack_q <= 1'b1; shf_q <= '0; ahi_q <= '0; addr_q <= '0;
    end else begin
      st_q <= st_d; bit_q <= bit_d; slot_q <= slot_d; drv_q <= drv_d;
      mack_q <= mack_d; shf_q <= shf_d; ahi_q <= ahi_d; addr_q <= addr_d;
    end
  end

  assign mem_addr  = addr_q;
  assign mem_wdata = shf_q;
  assign sda_oe    = drv_q | (st_q == ST_RDAT && !slot_q && !shf_q[7]);

  // R1: a mismatching select byte is never acknowledged
  a_r1_ack_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SEL && !slot_q && scl_fall && bit_q == LAST_BIT && !sel_match) |=> !sda_oe);
  // R6: SDA only moves while SCL is low
  a_r6_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_lvl);
  // R7: an idle target stays off the bus
  a_r7_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !start_det) |=> !sda_oe);
  // R8: counter wraps at the top
  a_r8_counter_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_inc && addr_q == '1) |=> addr_q == '0);
  // R10: stop releases SDA
  a_r10_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);
  // R11: start restarts select decode
  a_r11_start_resyncs: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st_q == ST_SEL && bit_q == '0));
endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target #(
  parameter int ADDR_W      = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       wp_i,
  input  logic [2:0] strap_i
);
  logic [1:0]        rst_pipe;
  logic              rst_core_n;
  logic              scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0]        mem_wdata, mem_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  i2cm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_core_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det));

  i2cm_frame #(.ADDR_W(ADDR_W)) u_frame (
    .clk(clk), .rst_n(rst_core_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .strap(strap_i), .wp(wp_i), .rd_data(mem_rdata),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .sda_oe(sda_oe));

  i2cm_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_array (
    .clk(clk), .we(mem_we), .waddr(mem_addr), .wdata(mem_wdata),
    .raddr(mem_addr), .rdata(mem_rdata));

  // R5: no array update while write protect is high
  a_r5_wp_blocks_write: assert property (@(posedge clk) disable iff (!rst_core_n)
    mem_we |-> !wp_i);
endmodule

// File: tb/tb_i2c_mem_target.sv
module tb_i2c_mem_target;
  localparam int AW   = 11;
  localparam int MASK = (1 << AW) - 1;
  localparam int Q    = 8;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, msda = 1'b1, wp = 1'b0;
  logic dut_oe;
  logic sda_bus;
  assign sda_bus = msda & ~dut_oe;

  always #2 clk = ~clk;

  i2c_mem_target #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe(dut_oe), .wp_i(wp), .strap_i(STRAP));

  int nchk = 0, nfail = 0;
  bit finished = 1'b0, armed = 1'b0;
  byte unsigned mm [int];
  int ptr = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R6: bus reference: the target must hold SDA while SCL is high
  logic prev_scl = 1'b0, prev_oe = 1'b0;
  always @(negedge clk) begin
    if (armed && scl && prev_scl) chk(dut_oe === prev_oe, "R6 oe stable scl high", dut_oe, prev_oe);
    prev_scl = scl; prev_oe = dut_oe;
  end

  task automatic wq(); repeat (Q) @(negedge clk); endtask
  task automatic i2c_start();
    msda = 1'b1; wq(); scl = 1'b1; wq(); msda = 1'b0; wq(); scl = 1'b0; wq();
  endtask
  task automatic i2c_stop();
    msda = 1'b0; wq(); scl = 1'b1; wq(); msda = 1'b1; wq(); wq();
  endtask
  task automatic bit_out(input logic b);
    msda = b; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
  endtask
  task automatic bit_in(output logic b);
    msda = 1'b1; wq(); scl = 1'b1; wq(); b = sda_bus; wq(); scl = 1'b0; wq();
  endtask
  task automatic send(input logic [7:0] b, input bit exp_ack, input string req);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(a);
    chk(a === !exp_ack, req, a, !exp_ack);
  endtask
  task automatic recv(input bit last, input string req);
    logic [7:0] d;
    int exp;
    for (int i = 7; i >= 0; i--) bit_in(d[i]);
    exp = mm.exists(ptr) ? mm[ptr] : -1;
    chk(d === exp[7:0] && exp >= 0, req, d, exp);
    ptr = (ptr + 1) & MASK;
    bit_out(last);
  endtask
  function automatic logic [7:0] sel(input logic rw);
    return {4'b1010, STRAP, rw};
  endfunction

  task automatic addr_phase(input logic [15:0] a, input string req);
    send(sel(1'b0), 1, "R1 write select ack");
    send(a[15:8], 1, req);
    send(a[7:0], 1, req);
    ptr = a & MASK;
  endtask
  task automatic wr_seq(input logic [15:0] a, input byte unsigned d[$], input string req);
    i2c_start();
    addr_phase(a, "R3 address ack");
    foreach (d[k]) begin
      send(d[k], 1, req);
      if (!wp) mm[ptr] = d[k];
      ptr = (ptr + 1) & MASK;
    end
    i2c_stop();
  endtask
  task automatic rd_rand(input logic [15:0] a, input int n, input string req);
    i2c_start();
    addr_phase(a, "R3 address ack");
    i2c_start();
    send(sel(1'b1), 1, "R9 read select ack");
    for (int k = 0; k < n; k++) recv(k == n - 1, req);
    i2c_stop();
  endtask
  task automatic rd_cont(input int n, input string req);
    i2c_start();
    send(sel(1'b1), 1, "R9 plain read select ack");
    for (int k = 0; k < n; k++) recv(k == n - 1, req);
    i2c_stop();
  endtask

  initial begin
    logic b;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(dut_oe === 1'b0, "R10 released after reset", dut_oe, 0);
    armed = 1'b1;

    wr_seq(16'h0010, '{8'h11, 8'h22, 8'h33, 8'h44}, "R4 write data ack");
    rd_rand(16'h0010, 4, "R6 random read data");
    wr_seq(16'h0014, '{8'h55, 8'h66}, "R4 write data ack");
    rd_rand(16'h0012, 2, "R9 random read data");
    rd_cont(2, "R9 continued read data");

    wr_seq(16'h07FE, '{8'hA5, 8'h5A, 8'hC3}, "R8 write across top");
    rd_rand(16'h07FF, 2, "R8 read across top");

    wr_seq(16'hF822, '{8'h77}, "R3 upper bits ignored write");
    rd_rand(16'h0022, 1, "R3 upper bits ignored read");

    wp = 1'b1;
    wr_seq(16'h0010, '{8'hEE, 8'hFF}, "R5 protected data still acked");
    wp = 1'b0;
    rd_rand(16'h0010, 2, "R5 array unchanged under protect");

    // R2: wrong strap, then following bytes ignored
    i2c_start();
    send({4'b1010, STRAP ^ 3'b010, 1'b0}, 0, "R2 wrong strap nack");
    send(8'h00, 0, "R2 later byte ignored");
    send(8'h10, 0, "R2 later byte ignored");
    send(8'hAA, 0, "R2 data ignored");
    i2c_stop();
    // R1: wrong type code
    i2c_start();
    send({4'b1011, STRAP, 1'b1}, 0, "R1 wrong type nack");
    i2c_stop();
    rd_rand(16'h0010, 1, "R2 memory untouched");

    // R7: after NACK, no drive
    i2c_start();
    addr_phase(16'h0011, "R3 address ack");
    i2c_start();
    send(sel(1'b1), 1, "R9 read select ack");
    recv(1'b1, "R7 read before nack");
    for (int k = 0; k < 9; k++) begin
      bit_in(b);
      chk(b === 1'b1, "R7 released after nack", b, 1);
    end
    i2c_stop();

    // R11: start in the middle of a select byte
    i2c_start();
    bit_out(1'b1); bit_out(1'b0); bit_out(1'b1); bit_out(1'b1);
    rd_rand(16'h07FF, 1, "R11 transfer after aborted byte");

    chk(dut_oe === 1'b0, "R10 released after stop", dut_oe, 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule